// File: doc/BRIEF.md
# Two-Stage System Watchdog Timer

The block is a countdown watchdog with a small byte-addressed register file. Software programs an initial tick count and then keeps the system alive by writing the reload register. The countdown moves by one on each pulse of an external prescaler tick. When the countdown runs out for the first time, the block sets a timeout flag, can raise a one-clock management interrupt, reloads and keeps counting. If the countdown runs out again with no reload write in between, the block sets second-timeout and boot flags and sends a one-clock system reset request. A strap input or a no-reboot control bit can block that request. When it is blocked, the second expiry behaves like a first one.

The register file also holds two mailbox bytes, two message bytes, a scratch byte and a software interrupt generation byte. A write to the inbound mailbox raises a status flag and an interrupt pulse. A write to the outbound mailbox raises a status flag only. A lock bit in the first control register can be set by software and is cleared only by reset.

The state machine has three states. IDLE means stopped, with the stage cleared. FIRST means running with no expiry pending. SECOND means running after one expiry.

Its transitions, in priority order:
- **Reload write.** From any state, go to FIRST with the countdown set to the timer value if the run condition holds. Otherwise go to IDLE and store the written value as the count.
- **Control-1 write.** From IDLE, go to FIRST if the run condition holds. From FIRST or SECOND, stay in the same state with the countdown reloaded. If the run condition fails, go to IDLE from any state.
- **Tick at expiry in FIRST.** Go to SECOND.
- **Tick at expiry in SECOND.** Go to IDLE if the reset request is issued. Otherwise go to FIRST.
- **Expiry with a timer value below 2.** From either running state, go to IDLE.

Top module: `twostage_wdog`

Register map (byte offsets, 16-bit values little-endian, low byte at the lower address; unmapped bytes read 0 and ignore writes):

| Offset | Name | Width | Reset |
|---|---|---|---|
| 0x00 | timer value | 16 (low CNT_W bits count) | 0x0004 |
| 0x02 | reload / remaining | 16 | 0x0000 |
| 0x04 | control 1: bit0 halt, bit1 lock | 16 | 0x0000 |
| 0x06 | control 2: bit0 no-reboot | 16 | 0x0008 |
| 0x08 | status 1: bit0 timeout, bit1 inbound mailbox, bit2 outbound mailbox | 16 | 0x0000 |
| 0x0A | status 2: bit0 second timeout, bit1 boot | 16 | 0x0000 |
| 0x0C / 0x0D | inbound / outbound mailbox | 8 each | 0x00 |
| 0x0E / 0x0F | message A / B | 8 each | 0x00 |
| 0x10 | scratch | 8 | 0x00 |
| 0x11 | software IRQ generation | 8 | 0x03 |

## Requirements
- R1: The countdown runs only when control-1 bit0 (halt) is 0 and the timer value is greater than 1. With a value of 0 or 1, or with halt set, a reload write stores the written value as the count and no expiry ever follows.
- R2: While running, each tick pulse lowers the count by one. The tick that would bring it to zero is an expiry, and every expiry sets status-1 bit0.
- R3: A first expiry pulses smi_pulse in the next cycle when smi_en is 1, reloads the count from the timer value and keeps running. With smi_en at 0 there is no pulse.
- R4: A second consecutive expiry sets status-2 bits 0 and 1. If strap_hold is 0 and control-2 bit0 is 0, it pulses rst_req, sends no smi_pulse, sets the count to 0 and stops.
- R5: When strap_hold is 1 or control-2 bit0 is 1, a second expiry sends no rst_req. It pulses smi_pulse (if smi_en is 1), reloads, and the next expiry counts as a first one again.
- R6: Any reload register write clears the pending stage. When R1 holds, the countdown also restarts from the timer value.
- R7: Control-1 bit1 (lock) is set by writing 1 and stays 1 through writes of 0 until reset.
- R8: A control-1 write restarts the countdown from the timer value if the R1 condition holds after the write, and stops it otherwise.
- R9: Reading the reload register returns the remaining count while running, and the stored count when stopped.
- R10: A write to the inbound mailbox stores the byte, sets status-1 bit1 and pulses smi_pulse in the next cycle whatever smi_en is. A write to the outbound mailbox stores the byte and sets status-1 bit2 with no pulse.
- R11: After reset the timer value reads 0x0004, control 2 reads 0x0008, the IRQ generation byte reads 0x03, and every other register reads 0.
- R12: bus_half=1 accesses two bytes at bus_addr and bus_addr+1, low byte first. bus_half=0 accesses one byte in bits 7:0.
- R13: A status register write replaces the flags with the written bits, masked to the defined ones. A hardware set in the same cycle wins.
- R14: smi_pulse and rst_req last exactly one clock per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Prescaler tick enable, one pulse per count step |
| strap_hold | input | 1 | Strap that blocks the reset request when 1 |
| smi_en | input | 1 | Enables the management interrupt on expiry |
| bus_wr | input | 1 | Write strobe for one access |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_half | input | 1 | 1 = 16-bit access, 0 = byte access |
| bus_wdata | input | 16 | Write data, low byte in bits 7:0 |
| bus_rdata | output | 16 | Combinational read data for bus_addr |
| smi_pulse | output | 1 | One-clock management interrupt pulse |
| rst_req | output | 1 | One-clock system reset request pulse |

## Verification
A wrong stage shows up only at the next expiry. The same number of ticks then gives a reset request where an interrupt was due, or the other way round. The directed sequence therefore drives pairs of full countdowns after each reload write and after each blocked second expiry. A wrong countdown value is visible at once through the reload register read, so the count is read back after partial tick runs. A lost lock bit or a wrong stop decision shows on the next control-1 read or reload read.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_FIRST  = 2'd1,
        S_SECOND = 2'd2
    } wd_state_t;

    // byte offsets of the register file
    localparam int OFS_TMR  = 0;
    localparam int OFS_RLD  = 2;
    localparam int OFS_CTL1 = 4;
    localparam int OFS_CTL2 = 6;
    localparam int OFS_ST1  = 8;
    localparam int OFS_ST2  = 10;
    localparam int OFS_DIN  = 12;
    localparam int OFS_DOUT = 13;
    localparam int OFS_MSGA = 14;
    localparam int OFS_MSGB = 15;
    localparam int OFS_SCR  = 16;
    localparam int OFS_SWI  = 17;
    localparam int NBYTE    = OFS_SWI + 1;

    // field positions
    localparam int C1_HALT   = 0;
    localparam int C1_LOCK   = 1;
    localparam int C2_NORB   = 0;
    localparam int ST1_TO    = 0;
    localparam int ST1_IN    = 1;
    localparam int ST1_OUT   = 2;
    localparam int ST2_SEC   = 0;
    localparam int ST2_BOOT  = 1;

endpackage

// File: rtl/wdog_regfile.sv
module wdog_regfile
    import wdog_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int CNT_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_half,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    input  logic [CNT_W-1:0]  cnt_now,
    input  logic              flag_to,
    input  logic              flag_second,
    output logic [CNT_W-1:0]  tmr_val,
    output logic              halt_nxt,
    output logic              noreboot,
    output logic              rld_wr,
    output logic [CNT_W-1:0]  rld_val,
    output logic              ctl1_wr,
    output logic              din_wr
);

    localparam logic [15:0] TMR_RST  = 16'h0004;
    localparam logic [15:0] CTL2_RST = 16'h0008;
    localparam logic [7:0]  SWI_RST  = 8'h03;

    logic [NBYTE-1:0] be;
    logic [7:0]       bd [NBYTE];
    logic [7:0]       rb [NBYTE];

    logic [15:0] tmr_r, ctl2_r, cnt16;
    logic        halt_r, lock_r;
    logic [2:0]  sts1_r, sts1_n;
    logic [1:0]  sts2_r, sts2_n;
    logic [7:0]  din_r, dout_r, msga_r, msgb_r, scr_r, swi_r;
    logic        dout_wr;

    assign cnt16 = 16'(cnt_now);

    // byte lane decode: low byte to bus_addr, high byte to bus_addr+1
    always_comb begin
        for (int i = 0; i < NBYTE; i++) begin
            be[i] = bus_wr && ((bus_addr == ADDR_W'(i)) ||
                               (bus_half && (bus_addr + ADDR_W'(1)) == ADDR_W'(i)));
            bd[i] = (bus_addr == ADDR_W'(i)) ? bus_wdata[7:0] : bus_wdata[15:8];
        end
    end

    assign rld_wr   = be[OFS_RLD] | be[OFS_RLD+1];
    assign ctl1_wr  = be[OFS_CTL1] | be[OFS_CTL1+1];
    assign din_wr   = be[OFS_DIN];
    assign dout_wr  = be[OFS_DOUT];
    assign halt_nxt = be[OFS_CTL1] ? bd[OFS_CTL1][C1_HALT] : halt_r;
    assign tmr_val  = tmr_r[CNT_W-1:0];
    assign noreboot = ctl2_r[C2_NORB];
    assign rld_val  = CNT_W'({be[OFS_RLD+1] ? bd[OFS_RLD+1] : cnt16[15:8],
                              be[OFS_RLD]   ? bd[OFS_RLD]   : cnt16[7:0]});

    // status: software write replaces, hardware sets win
    always_comb begin
        sts1_n = be[OFS_ST1] ? bd[OFS_ST1][2:0] : sts1_r;
        sts2_n = be[OFS_ST2] ? bd[OFS_ST2][1:0] : sts2_r;
        if (flag_to)     sts1_n[ST1_TO]   = 1'b1;
        if (din_wr)      sts1_n[ST1_IN]   = 1'b1;
        if (dout_wr)     sts1_n[ST1_OUT]  = 1'b1;
        if (flag_second) begin
            sts2_n[ST2_SEC]  = 1'b1;
            sts2_n[ST2_BOOT] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_r  <= TMR_RST;
            ctl2_r <= CTL2_RST;
            halt_r <= 1'b0;
            lock_r <= 1'b0;
            sts1_r <= '0;
            sts2_r <= '0;
            din_r  <= '0;
            dout_r <= '0;
            msga_r <= '0;
            msgb_r <= '0;
            scr_r  <= '0;
            swi_r  <= SWI_RST;
        end else begin
            if (be[OFS_TMR])    tmr_r[7:0]   <= bd[OFS_TMR];
            if (be[OFS_TMR+1])  tmr_r[15:8]  <= bd[OFS_TMR+1];
            if (be[OFS_CTL2])   ctl2_r[7:0]  <= bd[OFS_CTL2];
            if (be[OFS_CTL2+1]) ctl2_r[15:8] <= bd[OFS_CTL2+1];
            if (be[OFS_CTL1]) begin
                halt_r <= bd[OFS_CTL1][C1_HALT];
                if (bd[OFS_CTL1][C1_LOCK]) lock_r <= 1'b1;
            end
            sts1_r <= sts1_n;
            sts2_r <= sts2_n;
            if (din_wr)         din_r  <= bd[OFS_DIN];
            if (dout_wr)        dout_r <= bd[OFS_DOUT];
            if (be[OFS_MSGA])   msga_r <= bd[OFS_MSGA];
            if (be[OFS_MSGB])   msgb_r <= bd[OFS_MSGB];
            if (be[OFS_SCR])    scr_r  <= bd[OFS_SCR];
            if (be[OFS_SWI])    swi_r  <= bd[OFS_SWI];
        end
    end

    // read path
    always_comb begin
        for (int i = 0; i < NBYTE; i++) rb[i] = '0;
        rb[OFS_TMR]    = tmr_r[7:0];
        rb[OFS_TMR+1]  = tmr_r[15:8];
        rb[OFS_RLD]    = cnt16[7:0];
        rb[OFS_RLD+1]  = cnt16[15:8];
        rb[OFS_CTL1]   = {6'b0, lock_r, halt_r};
        rb[OFS_CTL2]   = ctl2_r[7:0];
        rb[OFS_CTL2+1] = ctl2_r[15:8];
        rb[OFS_ST1]    = {5'b0, sts1_r};
        rb[OFS_ST2]    = {6'b0, sts2_r};
        rb[OFS_DIN]    = din_r;
        rb[OFS_DOUT]   = dout_r;
        rb[OFS_MSGA]   = msga_r;
        rb[OFS_MSGB]   = msgb_r;
        rb[OFS_SCR]    = scr_r;
        rb[OFS_SWI]    = swi_r;
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NBYTE; i++) begin
            if (bus_addr == ADDR_W'(i)) bus_rdata[7:0] = rb[i];
            if (bus_half && (bus_addr + ADDR_W'(1)) == ADDR_W'(i)) bus_rdata[15:8] = rb[i];
        end
    end

    // R7: the lock bit never falls outside reset
    p_lock_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lock_r |=> lock_r);

    // R10: an inbound mailbox write leaves its status flag set
    p_inbox_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        din_wr |=> sts1_r[ST1_IN]);

endmodule

// File: rtl/wdog_core.sv
module wdog_core
    import wdog_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             strap_hold,
    input  logic             smi_en,
    input  logic             noreboot,
    input  logic             halt_nxt,
    input  logic             rld_wr,
    input  logic             ctl1_wr,
    input  logic             din_wr,
    input  logic [CNT_W-1:0] tmr_val,
    input  logic [CNT_W-1:0] rld_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic             flag_to,
    output logic             flag_second,
    output logic             smi_pulse,
    output logic             rst_req
);

    wd_state_t        st_q, st_n;
    logic [CNT_W-1:0] cnt_n;
    logic             smi_n, fire_n;
    logic             tmr_ok, can_go;

    assign tmr_ok = tmr_val > CNT_W'(1);
    assign can_go = !halt_nxt && tmr_ok;

    always_comb begin
        st_n        = st_q;
        cnt_n       = cnt_q;
        flag_to     = 1'b0;
        flag_second = 1'b0;
        smi_n       = din_wr;
        fire_n      = 1'b0;
        if (rld_wr) begin
            if (can_go) begin
                cnt_n = tmr_val;
                st_n  = S_FIRST;
            end else begin
                cnt_n = rld_val;
                st_n  = S_IDLE;
            end
        end else if (ctl1_wr) begin
            if (can_go) begin
                cnt_n = tmr_val;
                st_n  = (st_q == S_IDLE) ? S_FIRST : st_q;
            end else begin
                st_n  = S_IDLE;
            end
        end else if (tick) begin
            unique case (st_q)
                S_IDLE: st_n = S_IDLE;
                S_FIRST, S_SECOND: begin
                    if (cnt_q > CNT_W'(1)) begin
                        cnt_n = cnt_q - CNT_W'(1);
                    end else begin
                        flag_to     = 1'b1;
                        flag_second = (st_q == S_SECOND);
                        if (st_q == S_SECOND && !strap_hold && !noreboot) begin
                            fire_n = 1'b1;
                            st_n   = S_IDLE;
                            cnt_n  = '0;
                        end else begin
                            smi_n = smi_n | smi_en;
                            st_n  = (st_q == S_FIRST) ? S_SECOND : S_FIRST;
                            if (tmr_ok) begin
                                cnt_n = tmr_val;
                            end else begin
                                cnt_n = '0;
                                st_n  = S_IDLE;
                            end
                        end
                    end
                end
                default: st_n = S_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= S_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
        end
    end

    // output pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smi_pulse <= 1'b0;
            rst_req   <= 1'b0;
        end else begin
            smi_pulse <= smi_n;
            rst_req   <= fire_n;
        end
    end

    // R2: a running countdown never holds zero
    p_cnt_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != S_IDLE) |-> (cnt_q != '0));

    // R14: reset request lasts one clock
    p_rst_pulse_r14: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R4: the timer is stopped when a reset request is out
    p_rst_stops_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (st_q == S_IDLE));

    // R5: no reset request while strap or no-reboot blocked it
    p_rst_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (!$past(strap_hold) && !$past(noreboot)));

    // R4: reset request only follows an expiry in the second stage
    p_rst_stage_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> ($past(st_q) == S_SECOND));

endmodule

// File: rtl/twostage_wdog.sv
module twostage_wdog
    import wdog_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int CNT_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              strap_hold,
    input  logic              smi_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_half,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    output logic              smi_pulse,
    output logic              rst_req
);

    logic [CNT_W-1:0] cnt_q, tmr_val, rld_val;
    logic             flag_to, flag_second;
    logic             halt_nxt, noreboot, rld_wr, ctl1_wr, din_wr;

    wdog_regfile #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_half    (bus_half),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .cnt_now     (cnt_q),
        .flag_to     (flag_to),
        .flag_second (flag_second),
        .tmr_val     (tmr_val),
        .halt_nxt    (halt_nxt),
        .noreboot    (noreboot),
        .rld_wr      (rld_wr),
        .rld_val     (rld_val),
        .ctl1_wr     (ctl1_wr),
        .din_wr      (din_wr)
    );

    wdog_core #(.CNT_W(CNT_W)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .strap_hold  (strap_hold),
        .smi_en      (smi_en),
        .noreboot    (noreboot),
        .halt_nxt    (halt_nxt),
        .rld_wr      (rld_wr),
        .ctl1_wr     (ctl1_wr),
        .din_wr      (din_wr),
        .tmr_val     (tmr_val),
        .rld_val     (rld_val),
        .cnt_q       (cnt_q),
        .flag_to     (flag_to),
        .flag_second (flag_second),
        .smi_pulse   (smi_pulse),
        .rst_req     (rst_req)
    );

endmodule

// File: tb/twostage_wdog_bench.sv
module twostage_wdog_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        strap_hold = 1'b0;
    logic        smi_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_half = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        smi_pulse, rst_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    twostage_wdog u_twostage_wdog (
        .clk(clk), .rst_n(rst_n), .tick(tick), .strap_hold(strap_hold),
        .smi_en(smi_en), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_half(bus_half), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .smi_pulse(smi_pulse), .rst_req(rst_req)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic half, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_half = half; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input logic half, output logic [15:0] d);
        bus_addr = a; bus_half = half;
        #1;
        d = bus_rdata;
    endtask

    task automatic ticks(input int n, output int smis, output int rsts);
        smis = 0; rsts = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
            if (smi_pulse) smis++;
            if (rst_req)   rsts++;
        end
    endtask

    task automatic clr_status();
        wr(5'h08, 1'b1, 16'h0000);
        wr(5'h0A, 1'b1, 16'h0000);
    endtask

    task automatic t_reset_values();
        logic [15:0] d;
        rd(5'h00, 1'b1, d); chk("R11 timer", d, 16'h0004);
        rd(5'h06, 1'b1, d); chk("R11 ctl2", d, 16'h0008);
        rd(5'h11, 1'b0, d); chk("R11 swirq", d, 16'h0003);
        rd(5'h02, 1'b1, d); chk("R11 reload", d, 16'h0000);
        rd(5'h04, 1'b1, d); chk("R11 ctl1", d, 16'h0000);
        rd(5'h08, 1'b1, d); chk("R11 sts1", d, 16'h0000);
        chk("R11 pulses", {14'b0, smi_pulse, rst_req}, 16'h0000);
    endtask

    task automatic t_run_condition();
        logic [15:0] d; int s, r;
        smi_en = 1'b1;
        wr(5'h00, 1'b1, 16'h0001);
        wr(5'h02, 1'b1, 16'h0123);
        rd(5'h02, 1'b1, d); chk("R1 stored count tmr=1", d, 16'h0123);
        ticks(5, s, r); chk("R1 no expiry tmr=1", 16'(s + r), 16'h0000);
        wr(5'h00, 1'b1, 16'h0000);
        wr(5'h04, 1'b1, 16'h0000);
        ticks(4, s, r); chk("R1 no expiry tmr=0", 16'(s + r), 16'h0000);
        wr(5'h00, 1'b1, 16'h0005);
        wr(5'h04, 1'b1, 16'h0001);
        ticks(6, s, r); chk("R1 halted no expiry", 16'(s + r), 16'h0000);
        rd(5'h02, 1'b1, d); chk("R1 count unchanged when halted", d, 16'h0123);
        rd(5'h08, 1'b1, d); chk("R1 no timeout flag", d, 16'h0000);
    endtask

    task automatic t_first_expiry();
        logic [15:0] d; int s, r;
        wr(5'h04, 1'b1, 16'h0000);
        rd(5'h02, 1'b1, d); chk("R8 restart loads timer", d, 16'h0005);
        ticks(2, s, r);
        rd(5'h02, 1'b1, d); chk("R9 remaining after 2 ticks", d, 16'h0003);
        ticks(2, s, r); chk("R2 no early expiry", 16'(s + r), 16'h0000);
        ticks(1, s, r); chk("R3 smi on first expiry", 16'(s), 16'h0001);
        chk("R3 no reset on first expiry", 16'(r), 16'h0000);
        @(negedge clk); chk("R14 smi one clock", {15'b0, smi_pulse}, 16'h0000);
        rd(5'h08, 1'b1, d); chk("R2 timeout flag", d, 16'h0001);
        rd(5'h02, 1'b1, d); chk("R3 reloaded", d, 16'h0005);
    endtask

    task automatic t_status_write();
        logic [15:0] d;
        wr(5'h08, 1'b1, 16'h0000);
        rd(5'h08, 1'b1, d); chk("R13 sts1 cleared", d, 16'h0000);
        wr(5'h0A, 1'b1, 16'hFFFF);
        rd(5'h0A, 1'b1, d); chk("R13 sts2 masked", d, 16'h0003);
        wr(5'h0A, 1'b1, 16'h0000);
        rd(5'h0A, 1'b1, d); chk("R13 sts2 cleared", d, 16'h0000);
    endtask

    task automatic t_second_reset();
        logic [15:0] d; int s, r;
        ticks(5, s, r);
        chk("R4 reset on second expiry", 16'(r), 16'h0001);
        chk("R4 no smi with reset", 16'(s), 16'h0000);
        @(negedge clk); chk("R14 reset one clock", {15'b0, rst_req}, 16'h0000);
        rd(5'h0A, 1'b1, d); chk("R4 second and boot flags", d, 16'h0003);
        rd(5'h08, 1'b1, d); chk("R2 timeout flag on second", d, 16'h0001);
        rd(5'h02, 1'b1, d); chk("R4 count zero", d, 16'h0000);
        ticks(6, s, r); chk("R4 stopped after reset", 16'(s + r), 16'h0000);
        clr_status();
    endtask

    task automatic t_reload_clears();
        int s, r;
        wr(5'h02, 1'b1, 16'h0000);
        ticks(5, s, r); chk("R6 first after restart", 16'(s * 2 + r), 16'h0002);
        ticks(3, s, r);
        wr(5'h02, 1'b1, 16'h0000);
        ticks(5, s, r);
        chk("R6 stage cleared: smi", 16'(s), 16'h0001);
        chk("R6 stage cleared: no reset", 16'(r), 16'h0000);
    endtask

    task automatic t_blocked();
        logic [15:0] d; int s, r;
        strap_hold = 1'b1;
        ticks(5, s, r);
        chk("R5 strap blocks reset", 16'(r), 16'h0000);
        chk("R5 strap blocked smi", 16'(s), 16'h0001);
        rd(5'h0A, 1'b1, d); chk("R4 flags set when blocked", d, 16'h0003);
        strap_hold = 1'b0;
        wr(5'h06, 1'b0, 16'h0001);
        ticks(5, s, r); chk("R5 back to first stage", 16'(s * 2 + r), 16'h0002);
        ticks(5, s, r);
        chk("R5 no-reboot blocks reset", 16'(r), 16'h0000);
        chk("R5 no-reboot smi", 16'(s), 16'h0001);
        smi_en = 1'b0;
        ticks(5, s, r); chk("R3 smi gated by enable", 16'(s + r), 16'h0000);
        smi_en = 1'b1;
        clr_status();
    endtask

    task automatic t_lock();
        logic [15:0] d; int s, r;
        wr(5'h04, 1'b1, 16'h0003);
        rd(5'h04, 1'b1, d); chk("R7 lock set", d, 16'h0003);
        ticks(6, s, r); chk("R8 halt stops", 16'(s + r), 16'h0000);
        wr(5'h04, 1'b1, 16'h0000);
        rd(5'h04, 1'b1, d); chk("R7 lock sticky", d, 16'h0002);
        rd(5'h02, 1'b1, d); chk("R8 restart from timer", d, 16'h0005);
        ticks(1, s, r);
        rd(5'h02, 1'b1, d); chk("R8 running after restart", d, 16'h0004);
    endtask

    task automatic t_mailbox();
        logic [15:0] d;
        smi_en = 1'b0;
        wr(5'h0C, 1'b0, 16'h005A);
        chk("R10 inbound smi", {15'b0, smi_pulse}, 16'h0001);
        rd(5'h08, 1'b1, d); chk("R10 inbound flag", d, 16'h0002);
        rd(5'h0C, 1'b0, d); chk("R10 inbound data", d, 16'h005A);
        wr(5'h0D, 1'b0, 16'h00A5);
        chk("R10 outbound no smi", {15'b0, smi_pulse}, 16'h0000);
        rd(5'h08, 1'b1, d); chk("R10 outbound flag", d, 16'h0006);
        rd(5'h0D, 1'b0, d); chk("R10 outbound data", d, 16'h00A5);
        smi_en = 1'b1;
    endtask

    task automatic t_endian();
        logic [15:0] d;
        wr(5'h0E, 1'b1, 16'hBEEF);
        rd(5'h0F, 1'b0, d); chk("R12 high byte at addr+1", d, 16'h00BE);
        rd(5'h0E, 1'b0, d); chk("R12 low byte at addr", d, 16'h00EF);
        rd(5'h0E, 1'b1, d); chk("R12 half read", d, 16'hBEEF);
        wr(5'h10, 1'b0, 16'h9977);
        rd(5'h10, 1'b1, d); chk("R12 byte write keeps neighbour", d, 16'h0377);
    endtask

    task automatic t_reset_again();
        logic [15:0] d;
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd(5'h04, 1'b1, d); chk("R7 lock cleared by reset", d, 16'h0000);
        rd(5'h0E, 1'b1, d); chk("R11 messages cleared", d, 16'h0000);
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_values();
        t_run_condition();
        t_first_expiry();
        t_status_write();
        t_second_reset();
        t_reload_clears();
        t_blocked();
        t_lock();
        t_mailbox();
        t_endian();
        t_reset_again();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            summary();
            $finish;
        end
    end

endmodule